// File: doc/BRIEF.md
# Real-Time Calendar Counter

This block keeps time of day and calendar date. It receives a once-per-second tick pulse and holds eight byte-wide fields: seconds, minutes, hours, day of week, day of month, month, year and century. Each accepted tick advances the seconds, and every rollover carries into the next field up, as far as the century. Month lengths follow the calendar, and February gains its 29th day whenever the year within the century is a multiple of four.

Two global inputs set the interpretation of all fields. `bin_mode` chooses plain binary or packed BCD, and `hr24` chooses 24-hour or 12-hour counting, with the AM/PM flag held in bit 7 of the hour. Software can load any field through a plain write strobe, which is accepted every cycle and never back-pressured. It reads all fields directly from the output ports. While `freeze` is high, incoming ticks are discarded, so software can read or load a consistent snapshot. Clock generation, prescaling and bus decoding sit outside this block.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours, year and century are 0, day of week, day of month and month are 1, and `upd` is 0.
- R2: A tick sampled while `freeze` is 0 raises `upd` in the next cycle for exactly one cycle. The fields take their advanced values at the end of that `upd` cycle.
- R3: A tick sampled while `freeze` is 1 is dropped. It is never queued, `upd` stays 0, and no field changes.
- R4: Seconds and minutes count 0 to 59. The step from 59 returns the field to 0 and advances the next field.
- R5: With `bin_mode`=1 fields are plain binary. With `bin_mode`=0 each field is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R6: With `hr24`=1 the hour counts 0 to 23, and the step from 23 returns it to 0 and advances the day.
- R7: With `hr24`=0 the hour, held in bits 6:0, counts 1 to 12, and bit 7 is 1 for PM. The step from 11 goes to 12 and toggles bit 7. The step from 12 goes to 1 and keeps bit 7. The day advances only on the step from 11 PM to 12 AM.
- R8: The day of month wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except February. February wraps after 29 when the year is divisible by 4, and after 28 otherwise. Each wrap advances the month.
- R9: Month wraps 12 to 1 and advances the year. Year wraps 99 to 0 and advances the century. Century wraps 99 to 0.
- R10: Day of week counts 1 to 7 (1 = Sunday) and advances on each day carry. It wraps 7 to 1.
- R11: A write with `wr_en`=1 loads `wr_data` into the field chosen by `wr_sel`, visible from the next cycle, whether or not `freeze` is set. The `wr_sel` codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year and 7 century. Codes 8 to 15 change nothing. A write that lands in an `upd` cycle takes precedence over the advance for its field.
- R12: A field whose decoded value is at or above its maximum returns to its minimum on its next advance and carries onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| freeze | input | 1 | 1 = drop ticks, fields hold |
| bin_mode | input | 1 | 1 = binary, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 4 | Field code for the write |
| wr_data | input | 8 | Raw value written |
| t_sec | output | 8 | Seconds |
| t_min | output | 8 | Minutes |
| t_hour | output | 8 | Hours |
| t_dow | output | 8 | Day of week |
| t_dom | output | 8 | Day of month |
| t_mon | output | 8 | Month |
| t_year | output | 8 | Year in century |
| t_cent | output | 8 | Century |
| upd | output | 1 | High in the cycle the carry chain is applied |

## Verification
The hardest situations to reach from the ports are the long carries, such as a BCD New Year's Eve rippling into the century, a 12-hour 11 PM rollover, and a leap-year February. Left to the tick alone, each would take millions of cycles. The stimulus sets `freeze`, loads every field to one step short of the boundary through the write port, releases `freeze` and issues a single tick. A second hard case is a host write landing exactly in the `upd` cycle. The stimulus reaches it by driving the write one cycle after the tick. A behavioural model is compared with the ports on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FW = 8;
  localparam int NF = 8;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HOUR, F_DOW, F_DOM, F_MON, F_YEAR, F_CENT
  } fld_e;

  function automatic logic [FW-1:0] fdec(input logic [FW-1:0] v, input logic bin);
    return bin ? v : 8'({4'b0, v[7:4]} * 8'd10 + {4'b0, v[3:0]});
  endfunction

  function automatic logic [FW-1:0] fenc(input logic [FW-1:0] n, input logic bin);
    return bin ? n : 8'((n / 8'd10) * 8'd16 + (n % 8'd10));
  endfunction

  function automatic logic [FW-1:0] rst_val(input int idx);
    return (idx == int'(F_DOW) || idx == int'(F_DOM) || idx == int'(F_MON)) ? 8'd1 : 8'd0;
  endfunction
endpackage

// File: rtl/rtc_wrap_step.sv
module rtc_wrap_step
  import rtc_pkg::*;
(
  input  logic [FW-1:0] cur,
  input  logic          bin,
  input  logic          inc,
  input  logic [FW-1:0] lo,
  input  logic [FW-1:0] hi,
  output logic [FW-1:0] nxt,
  output logic          wrap
);
  logic [FW-1:0] n;
  assign n    = fdec(cur, bin);
  assign wrap = inc && (n >= hi);
  always_comb begin
    if (!inc)     nxt = cur;
    else if (wrap) nxt = fenc(lo, bin);
    else          nxt = fenc(FW'(n + 8'd1), bin);
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_pkg::*;
(
  input  logic [FW-1:0] cur,
  input  logic          bin,
  input  logic          h24,
  input  logic          inc,
  output logic [FW-1:0] nxt,
  output logic          day_cy
);
  logic [FW-1:0] n24, n12;
  logic          pm;
  assign n24 = fdec(cur, bin);
  assign n12 = fdec({1'b0, cur[6:0]}, bin);
  assign pm  = cur[7];

  always_comb begin
    nxt    = cur;
    day_cy = 1'b0;
    if (inc) begin
      if (h24) begin
        if (n24 >= 8'd23) begin
          nxt    = fenc(8'd0, bin);
          day_cy = 1'b1;
        end else begin
          nxt = fenc(FW'(n24 + 8'd1), bin);
        end
      end else if (n12 == 8'd11) begin
        nxt    = {~pm, 7'(fenc(8'd12, bin))};
        day_cy = pm;
      end else if (n12 >= 8'd12) begin
        nxt = {pm, 7'(fenc(8'd1, bin))};
      end else begin
        nxt = {pm, 7'(fenc(FW'(n12 + 8'd1), bin))};
      end
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [FW-1:0] mon,
  input  logic [FW-1:0] year,
  input  logic          bin,
  output logic [FW-1:0] len
);
  logic [FW-1:0] m, y;
  assign m = fdec(mon, bin);
  assign y = fdec(year, bin);
  always_comb begin
    if (m == 8'd2)
      len = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
    else if (m == 8'd4 || m == 8'd6 || m == 8'd9 || m == 8'd11)
      len = 8'd30;
    else
      len = 8'd31;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             freeze,
  input  logic             bin_mode,
  input  logic             hr24,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [FW-1:0]    wr_data,
  output logic [FW-1:0]    t_sec,
  output logic [FW-1:0]    t_min,
  output logic [FW-1:0]    t_hour,
  output logic [FW-1:0]    t_dow,
  output logic [FW-1:0]    t_dom,
  output logic [FW-1:0]    t_mon,
  output logic [FW-1:0]    t_year,
  output logic [FW-1:0]    t_cent,
  output logic             upd
);
  logic [NF-1:0][FW-1:0] fld, nxt;
  logic cy_sec, cy_min, cy_day, cy_dom, cy_mon, cy_year, cy_cent, cy_dow;
  logic [FW-1:0] mlen;

  rtc_wrap_step u_sec (.cur(fld[F_SEC]), .bin(bin_mode), .inc(upd),
    .lo(8'd0), .hi(8'd59), .nxt(nxt[F_SEC]), .wrap(cy_sec));
  rtc_wrap_step u_min (.cur(fld[F_MIN]), .bin(bin_mode), .inc(cy_sec),
    .lo(8'd0), .hi(8'd59), .nxt(nxt[F_MIN]), .wrap(cy_min));
  rtc_hour_step u_hour (.cur(fld[F_HOUR]), .bin(bin_mode), .h24(hr24), .inc(cy_min),
    .nxt(nxt[F_HOUR]), .day_cy(cy_day));
  rtc_wrap_step u_dow (.cur(fld[F_DOW]), .bin(bin_mode), .inc(cy_day),
    .lo(8'd1), .hi(8'd7), .nxt(nxt[F_DOW]), .wrap(cy_dow));
  rtc_month_len u_mlen (.mon(fld[F_MON]), .year(fld[F_YEAR]), .bin(bin_mode), .len(mlen));
  rtc_wrap_step u_dom (.cur(fld[F_DOM]), .bin(bin_mode), .inc(cy_day),
    .lo(8'd1), .hi(mlen), .nxt(nxt[F_DOM]), .wrap(cy_dom));
  rtc_wrap_step u_mon (.cur(fld[F_MON]), .bin(bin_mode), .inc(cy_dom),
    .lo(8'd1), .hi(8'd12), .nxt(nxt[F_MON]), .wrap(cy_mon));
  rtc_wrap_step u_year (.cur(fld[F_YEAR]), .bin(bin_mode), .inc(cy_mon),
    .lo(8'd0), .hi(8'd99), .nxt(nxt[F_YEAR]), .wrap(cy_year));
  rtc_wrap_step u_cent (.cur(fld[F_CENT]), .bin(bin_mode), .inc(cy_year),
    .lo(8'd0), .hi(8'd99), .nxt(nxt[F_CENT]), .wrap(cy_cent));

  always_ff @(posedge clk) begin
    if (!rst_n) upd <= 1'b0;
    else        upd <= tick && !freeze;
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)
        fld[i] <= rst_val(i);
      else if (wr_en && wr_sel == SEL_W'(i))
        fld[i] <= wr_data;
      else
        fld[i] <= nxt[i];
    end
  end

  assign t_sec  = fld[F_SEC];
  assign t_min  = fld[F_MIN];
  assign t_hour = fld[F_HOUR];
  assign t_dow  = fld[F_DOW];
  assign t_dom  = fld[F_DOM];
  assign t_mon  = fld[F_MON];
  assign t_year = fld[F_YEAR];
  assign t_cent = fld[F_CENT];

  logic unused_cy;
  assign unused_cy = cy_cent ^ cy_dow;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       freeze,
  input logic       wr_en,
  input logic [3:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] t_sec,
  input logic [7:0] t_min,
  input logic [7:0] t_hour,
  input logic [7:0] t_dow,
  input logic [7:0] t_dom,
  input logic [7:0] t_mon,
  input logic [7:0] t_year,
  input logic [7:0] t_cent,
  input logic       upd
);
  logic [63:0] all_f;
  assign all_f = {t_sec, t_min, t_hour, t_dow, t_dom, t_mon, t_year, t_cent};

  AST_TICK_STARTS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze) |=> upd); // R2
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !tick) |=> !upd); // R2
  AST_FROZEN_TICK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !upd); // R3
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !wr_en) |=> $stable(all_f)); // R3
  AST_UPD_MOVES_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en) |=> (t_sec != $past(t_sec))); // R4
  AST_WRITE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'd0) |=> (t_sec == $past(wr_data))); // R11
  AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[3] && !upd) |=> $stable(all_f)); // R11
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, freeze = 0, bin_mode = 1, hr24 = 1, wr_en = 0;
  logic [3:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] t_sec, t_min, t_hour, t_dow, t_dom, t_mon, t_year, t_cent;
  logic upd;

  always #2.5 clk = ~clk;

  rtc_calendar u_rtc_calendar (.clk, .rst_n, .tick, .freeze, .bin_mode, .hr24,
    .wr_en, .wr_sel, .wr_data, .t_sec, .t_min, .t_hour, .t_dow, .t_dom,
    .t_mon, .t_year, .t_cent, .upd);

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  int m [8];
  bit m_upd = 0;
  bit done = 0;

  function automatic int dec(int v, bit bin);
    return bin ? v : (v / 16) * 10 + (v % 16);
  endfunction
  function automatic int enc(int n, bit bin);
    return bin ? n : (n / 10) * 16 + (n % 10);
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) m[i] = (i >= 3 && i <= 5) ? 1 : 0;
    m_upd = 0;
  endfunction

  // advance the model by one second
  function automatic void model_adv(bit b, bit h24);
    int v, len, mo, yr;
    bit c, pm;
    v = dec(m[0], b); c = (v >= 59); m[0] = enc(c ? 0 : v + 1, b);
    if (!c) return;
    v = dec(m[1], b); c = (v >= 59); m[1] = enc(c ? 0 : v + 1, b);
    if (!c) return;
    if (h24) begin
      v = dec(m[2], b); c = (v >= 23); m[2] = enc(c ? 0 : v + 1, b);
    end else begin
      pm = m[2][7]; v = dec(m[2] & 127, b); c = 0;
      if (v == 11) begin v = 12; c = pm; pm = !pm; end
      else if (v >= 12) v = 1;
      else v++;
      m[2] = enc(v, b) | (pm ? 128 : 0);
    end
    if (!c) return;
    v = dec(m[3], b); m[3] = enc((v >= 7) ? 1 : v + 1, b);
    mo = dec(m[5], b); yr = dec(m[6], b);
    if (mo == 2) len = (yr % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) len = 30;
    else len = 31;
    v = dec(m[4], b); c = (v >= len); m[4] = enc(c ? 1 : v + 1, b);
    if (!c) return;
    v = mo; c = (v >= 12); m[5] = enc(c ? 1 : v + 1, b);
    if (!c) return;
    v = yr; c = (v >= 99); m[6] = enc(c ? 0 : v + 1, b);
    if (!c) return;
    v = dec(m[7], b); m[7] = enc((v >= 99) ? 0 : v + 1, b);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else begin
      bit nu;
      nu = tick && !freeze;
      if (m_upd) model_adv(bin_mode, hr24);
      if (wr_en && wr_sel < 8) m[wr_sel] = int'(wr_data);
      m_upd = nu;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " upd"}, int'(upd), int'(m_upd));
      chk({cur_req, " fields"},
          int'({t_sec, t_min, t_hour, t_dow}), (m[0] << 24) | (m[1] << 16) | (m[2] << 8) | m[3]);
      chk({cur_req, " date"},
          int'({t_dom, t_mon, t_year, t_cent}), (m[4] << 24) | (m[5] << 16) | (m[6] << 8) | m[7]);
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk); wr_en = 1; wr_sel = 4'(sel); wr_data = 8'(data);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  task automatic load(int s, int mi, int h, int dw, int dm, int mo, int y, int c);
    freeze = 1;
    wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dm); wr(5, mo); wr(6, y); wr(7, c);
    @(negedge clk); freeze = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", int'({t_sec, t_min, t_hour, t_dow}), 32'h00000001);
    chk("R1 reset", int'({t_dom, t_mon, t_year, t_cent}), 32'h01010000);
    chk("R1 upd", int'(upd), 0);

    cur_req = "R2";
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    chk("R2 upd high", int'(upd), 1);
    @(negedge clk);
    chk("R2 upd low", int'(upd), 0);
    chk("R2 sec", int'(t_sec), 1);

    cur_req = "R3";
    freeze = 1; pulse(); pulse();
    chk("R3 frozen", int'(t_sec), 1);
    freeze = 0;

    cur_req = "R4";
    wr(0, 58); pulse(); pulse();
    chk("R4 sec wrap", int'(t_sec), 0);
    chk("R4 min carry", int'(t_min), 1);

    cur_req = "R6";
    load(59, 59, 23, 3, 10, 6, 20, 20); pulse();
    chk("R6 hour wrap", int'(t_hour), 0);
    chk("R6 day carry", int'(t_dom), 11);

    cur_req = "R8";
    load(59, 59, 23, 1, 28, 2, 4, 20); pulse();
    chk("R8 leap feb 29", int'({t_dom, t_mon}), 16'h1D02);
    load(59, 59, 23, 1, 28, 2, 3, 20); pulse();
    chk("R8 plain feb", int'({t_dom, t_mon}), 16'h0103);
    load(59, 59, 23, 1, 30, 4, 3, 20); pulse();
    chk("R8 april 30", int'({t_dom, t_mon}), 16'h0105);

    cur_req = "R9";
    bin_mode = 0;
    load('h59, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99, 'h19); pulse();
    chk("R9 R5 bcd new year", int'({t_sec, t_min, t_hour, t_dow}), 32'h00000001);
    chk("R9 R5 bcd new year", int'({t_dom, t_mon, t_year, t_cent}), 32'h01010020);
    cur_req = "R10";
    chk("R10 dow wrap", int'(t_dow), 1);
    load('h59, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99, 'h99); pulse();
    chk("R9 cent wrap", int'(t_cent), 0);

    cur_req = "R7";
    hr24 = 0;
    load('h59, 'h59, 'h11, 'h02, 'h05, 'h01, 'h10, 'h20); pulse();
    chk("R7 11AM->12PM", int'(t_hour), 'h92);
    wr(0, 'h59); wr(1, 'h59); pulse();
    chk("R7 12PM->1PM", int'(t_hour), 'h81);
    load('h59, 'h59, 'h91, 'h02, 'h05, 'h01, 'h10, 'h20); pulse();
    chk("R7 11PM->12AM", int'(t_hour), 'h12);
    chk("R7 day carry", int'(t_dom), 'h06);
    bin_mode = 1;
    load(59, 59, 'h8B, 2, 5, 1, 10, 20); pulse();
    chk("R7 R5 binary 11PM", int'({t_hour, t_dom}), 16'h0C06);
    hr24 = 1;

    cur_req = "R11";
    load(10, 0, 0, 1, 1, 1, 0, 20);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; wr_en = 1; wr_sel = 0; wr_data = 8'd30;
    @(negedge clk); wr_en = 0;
    chk("R11 write beats advance", int'(t_sec), 30);
    wr(9, 'h55); wr(15, 'hAA);
    chk("R11 bad sel ignored", int'({t_sec, t_min, t_hour, t_dow}), 32'h1E000001);

    cur_req = "R12";
    wr(0, 100); pulse();
    chk("R12 out of range sec", int'({t_sec, t_min}), 16'h0001);

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule